// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a handful of recently used page-table entries close to the processor so that most virtual-to-physical translations avoid a trip to memory. It accepts one lookup at a time. The incoming virtual page number is compared against every resident entry in parallel. A match returns the frame number, the protection bits and the modified bit one cycle later, and the page table is not touched.

When no entry matches, the block raises a single request toward the page-table side and holds it until the reply arrives. A present reply is written over a victim slot and is also returned to the requester. A reply marked not present is returned as a fault and leaves the contents unchanged. The victim is the lowest-numbered free slot if one exists. Otherwise a rotating pointer picks the victim. A flush input empties the whole cache in one cycle. Two free-running counters report how many lookups hit and how many missed.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `ready_o` is 1, `rsp_valid_o` and `pt_req_o` are 0, and both counters read 0.
- R2: An accepted lookup (`req_valid_i` and `ready_o` high at a clock edge) whose page number matches a valid entry drives `rsp_valid_o`=1 and `rsp_hit_o`=1 in the next cycle, with that entry's frame, protection and modified bit. `pt_req_o` stays 0.
- R3: An accepted lookup that matches no entry raises `pt_req_o` in the next cycle, with `pt_vpn_o` equal to the looked-up page number. The request stays high until the cycle in which `pt_rsp_valid_i` is sampled high. Each miss produces exactly one request.
- R4: A reply with `pt_rsp_present_i`=1 produces `rsp_valid_o`=1, `rsp_hit_o`=0 and `rsp_fault_o`=0 in the next cycle, carrying the reply's fields. The entry is installed, so a later lookup of the same page hits.
- R5: While any slot is free, a fill goes to the lowest-numbered free slot.
- R6: When every slot is valid, a fill replaces the slot named by a rotating pointer. The pointer starts at 0, advances by one after every fill (into a free slot or not) and wraps from N-1 to 0. A flush does not move it.
- R7: A reply with `pt_rsp_present_i`=0 produces `rsp_valid_o`=1, `rsp_fault_o`=1 and `rsp_hit_o`=0, installs nothing and leaves the pointer unchanged.
- R8: While `flush_i` is high, `ready_o` is 0 and no lookup is accepted. From the next cycle on, every entry is invalid, and a fill that coincides with the flush is dropped.
- R9: While a miss is outstanding, `ready_o` is 0 and lookups are ignored. They produce no response, no counter change and no change of `pt_vpn_o`.
- R10: `hit_count_o` counts accepted lookups that hit and `miss_count_o` counts accepted lookups that missed. Both wrap.
- R11: At most one entry matches any page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_vpn_i | input | 20 | Virtual page number to translate |
| ready_o | output | 1 | Lookup can be accepted this cycle |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Response came from a resident entry |
| rsp_fault_o | output | 1 | Page not present |
| rsp_pfn_o | output | 20 | Frame number |
| rsp_prot_o | output | 3 | Protection bits |
| rsp_dirty_o | output | 1 | Modified bit |
| pt_req_o | output | 1 | Page-table read request, level held until reply |
| pt_vpn_o | output | 20 | Page number being fetched |
| pt_rsp_valid_i | input | 1 | Page-table reply strobe |
| pt_rsp_present_i | input | 1 | Reply entry is present |
| pt_rsp_pfn_i | input | 20 | Reply frame number |
| pt_rsp_prot_i | input | 3 | Reply protection bits |
| pt_rsp_dirty_i | input | 1 | Reply modified bit |
| hit_count_o | output | 16 | Accepted hits |
| miss_count_o | output | 16 | Accepted misses |

## Verification
The hardest case to reach from the ports is the choice between a free slot and the rotating pointer after a flush. The pointer has drifted away from zero by then, and the bug only shows when the two rules would pick different slots. The stimulus first fills the cache, forces rotating evictions, then stalls the pointer with fault replies. It then flushes while the pointer is mid-rotation and refills all eight slots. The next eviction reveals which slot holds which page, because one specific page must survive and another must be gone.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned PROT_W = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PROT_W-1:0] prot;
    logic              dirty;
  } xlat_entry_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } miss_state_e;
endpackage

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
  import xlat_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  xlat_entry_t      fill_entry_i,
  input  logic [VPN_W-1:0] lookup_vpn_i,
  output logic [N-1:0]     valid_o,
  output logic             hit_o,
  output xlat_entry_t      hit_entry_o
);
  logic [N-1:0] match_vec;
  xlat_entry_t  ent_w [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic        v_q;
    xlat_entry_t e_q;
    logic        sel;

    assign sel = fill_en_i && (fill_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      v_q <= 1'b0;
      else if (flush_i) v_q <= 1'b0;
      else if (sel)     v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel && !flush_i) e_q <= fill_entry_i;
    end

    assign valid_o[g]   = v_q;
    assign ent_w[g]     = e_q;
    assign match_vec[g] = v_q && (e_q.vpn == lookup_vpn_i);
  end

  always_comb begin
    hit_entry_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) hit_entry_o = ent_w[i];
    end
  end

  assign hit_o = |match_vec;

  // R11: parallel compare never yields two matches
  p_single_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R8: flush leaves every slot empty
  p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0));
endmodule

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             advance_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] first_free;
  logic             any_free;

  always_comb begin
    first_free = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) first_free = IDX_W'(i);
    end
  end

  assign any_free = ~&valid_i;
  assign victim_o = any_free ? first_free : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (advance_i) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R5: a free slot is always preferred over an occupied one
  p_free_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_free |-> !valid_i[victim_o]);
endmodule

// File: rtl/xlat_miss_ctrl.sv
module xlat_miss_ctrl
  import xlat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic req_valid_i,
  input  logic hit_i,
  input  logic pt_rsp_valid_i,
  input  logic pt_rsp_present_i,
  output logic ready_o,
  output logic accept_hit_o,
  output logic accept_miss_o,
  output logic pt_req_o,
  output logic reply_o,
  output logic fill_en_o
);
  miss_state_e state_q, state_d;
  logic        accept;

  assign ready_o       = (state_q == ST_IDLE) && !flush_i;
  assign accept        = req_valid_i && ready_o;
  assign accept_hit_o  = accept && hit_i;
  assign accept_miss_o = accept && !hit_i;
  assign pt_req_o      = (state_q == ST_WAIT);
  assign reply_o       = pt_req_o && pt_rsp_valid_i;
  assign fill_en_o     = reply_o && pt_rsp_present_i && !flush_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_miss_o) state_d = ST_WAIT;
      ST_WAIT: if (pt_rsp_valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R3: request held until the reply strobe
  p_req_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_req_o && !pt_rsp_valid_i) |=> pt_req_o);

  // R9: nothing accepted while a miss is outstanding
  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_req_o |-> !accept);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned CNT_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_valid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_fault_o,
  output logic [PFN_W-1:0]  rsp_pfn_o,
  output logic [PROT_W-1:0] rsp_prot_o,
  output logic              rsp_dirty_o,
  output logic              pt_req_o,
  output logic [VPN_W-1:0]  pt_vpn_o,
  input  logic              pt_rsp_valid_i,
  input  logic              pt_rsp_present_i,
  input  logic [PFN_W-1:0]  pt_rsp_pfn_i,
  input  logic [PROT_W-1:0] pt_rsp_prot_i,
  input  logic              pt_rsp_dirty_i,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0] valid_vec;
  logic                   hit;
  xlat_entry_t            hit_entry, fill_entry;
  logic [IDX_W-1:0]       victim;
  logic                   accept_hit, accept_miss, reply, fill_en;
  logic [VPN_W-1:0]       pend_vpn_q;

  assign fill_entry = '{vpn: pend_vpn_q, pfn: pt_rsp_pfn_i,
                        prot: pt_rsp_prot_i, dirty: pt_rsp_dirty_i};

  xlat_entry_array #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .fill_en_i    (fill_en),
    .fill_idx_i   (victim),
    .fill_entry_i (fill_entry),
    .lookup_vpn_i (req_vpn_i),
    .valid_o      (valid_vec),
    .hit_o        (hit),
    .hit_entry_o  (hit_entry)
  );

  xlat_victim_sel #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_vec),
    .advance_i (fill_en),
    .victim_o  (victim)
  );

  xlat_miss_ctrl u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .flush_i          (flush_i),
    .req_valid_i      (req_valid_i),
    .hit_i            (hit),
    .pt_rsp_valid_i   (pt_rsp_valid_i),
    .pt_rsp_present_i (pt_rsp_present_i),
    .ready_o          (ready_o),
    .accept_hit_o     (accept_hit),
    .accept_miss_o    (accept_miss),
    .pt_req_o         (pt_req_o),
    .reply_o          (reply),
    .fill_en_o        (fill_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_vpn_q <= '0;
    else if (accept_miss) pend_vpn_q <= req_vpn_i;
  end
  assign pt_vpn_o = pend_vpn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_pfn_o   <= '0;
      rsp_prot_o  <= '0;
      rsp_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= accept_hit || reply;
      if (accept_hit) begin
        rsp_hit_o   <= 1'b1;
        rsp_fault_o <= 1'b0;
        rsp_pfn_o   <= hit_entry.pfn;
        rsp_prot_o  <= hit_entry.prot;
        rsp_dirty_o <= hit_entry.dirty;
      end else if (reply) begin
        rsp_hit_o   <= 1'b0;
        rsp_fault_o <= !pt_rsp_present_i;
        rsp_pfn_o   <= pt_rsp_pfn_i;
        rsp_prot_o  <= pt_rsp_prot_i;
        rsp_dirty_o <= pt_rsp_dirty_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_count_o  <= '0;
      miss_count_o <= '0;
    end else begin
      if (accept_hit)  hit_count_o  <= hit_count_o + 1'b1;
      if (accept_miss) miss_count_o <= miss_count_o + 1'b1;
    end
  end

  // R2: a resident page answers in the next cycle without a fetch
  p_hit_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o && hit) |=> (rsp_valid_o && rsp_hit_o && !pt_req_o));

  // R3: a miss raises the fetch in the next cycle
  p_miss_fetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ready_o && !hit) |=> (pt_req_o && !rsp_valid_o));

  // R4: a non-hit response always follows a reply strobe
  p_fill_after_reply_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> $past(pt_rsp_valid_i && pt_req_o));

  // R7: a fault never claims a hit and never fills a slot
  p_fault_no_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_req_o && pt_rsp_valid_i && !pt_rsp_present_i) |=>
      (rsp_fault_o && !rsp_hit_o && $stable(valid_vec)));
endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        ready, rsp_valid, rsp_hit, rsp_fault, rsp_dirty, pt_req;
  logic [19:0] rsp_pfn, pt_vpn;
  logic [2:0]  rsp_prot;
  logic        pt_valid = 1'b0, pt_present = 1'b0, pt_dirty = 1'b0;
  logic [19:0] pt_pfn = '0;
  logic [2:0]  pt_prot = '0;
  logic [15:0] hit_cnt, miss_cnt;

  int checks = 0, fails = 0;
  int exp_hits = 0, exp_misses = 0, pt_req_edges = 0;
  logic        pt_req_prev = 1'b0;

  logic [19:0] m_vpn [N];
  logic        m_val [N];
  int          m_ptr = 0;

  always #5 clk = ~clk;

  xlat_cache dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_vpn_i(req_vpn), .ready_o(ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault),
    .rsp_pfn_o(rsp_pfn), .rsp_prot_o(rsp_prot), .rsp_dirty_o(rsp_dirty),
    .pt_req_o(pt_req), .pt_vpn_o(pt_vpn),
    .pt_rsp_valid_i(pt_valid), .pt_rsp_present_i(pt_present),
    .pt_rsp_pfn_i(pt_pfn), .pt_rsp_prot_i(pt_prot), .pt_rsp_dirty_i(pt_dirty),
    .hit_count_o(hit_cnt), .miss_count_o(miss_cnt)
  );

  always @(negedge clk) begin
    if (pt_req && !pt_req_prev) pt_req_edges++;
    pt_req_prev <= pt_req;
  end

  function automatic logic [19:0] f_pfn(input logic [19:0] v);
    return {v[9:0], v[19:10]} ^ 20'h0F0F0;
  endfunction
  function automatic logic [2:0] f_prot(input logic [19:0] v);
    return v[2:0];
  endfunction
  function automatic logic f_dirty(input logic [19:0] v);
    return v[0] ^ v[4];
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_find(input logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic model_fill(input logic [19:0] v);
    int slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_val[i]) slot = i;
    if (slot < 0) slot = m_ptr;
    m_val[slot] = 1'b1;
    m_vpn[slot] = v;
    m_ptr = (m_ptr + 1) % N;
  endtask

  task automatic reply_and_check(input logic [19:0] v, input string tag);
    logic present = !v[19];
    repeat (2) begin
      @(negedge clk);
      chk(pt_req == 1'b1, "R3", "request held", 32'(pt_req), 1);
    end
    pt_valid = 1'b1; pt_present = present;
    pt_pfn = f_pfn(v); pt_prot = f_prot(v); pt_dirty = f_dirty(v);
    @(negedge clk);
    pt_valid = 1'b0;
    chk(rsp_valid && !rsp_hit, tag, "fill response", {rsp_valid, rsp_hit}, 2'b10);
    chk(rsp_fault == !present, present ? "R4" : "R7", "fault flag", 32'(rsp_fault), 32'(!present));
    if (present) begin
      chk(rsp_pfn == f_pfn(v), "R4", "fill pfn", rsp_pfn, f_pfn(v));
      model_fill(v);
    end
    chk(pt_req == 1'b0, "R3", "request dropped", 32'(pt_req), 0);
  endtask

  task automatic do_lookup(input logic [19:0] v, input string tag);
    bit exp_hit = (model_find(v) >= 0);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      exp_hits++;
      chk(rsp_valid && rsp_hit, tag, "hit response", {rsp_valid, rsp_hit}, 2'b11);
      chk(rsp_pfn == f_pfn(v) && rsp_prot == f_prot(v) && rsp_dirty == f_dirty(v),
          "R2", "hit fields", rsp_pfn, f_pfn(v));
      chk(!pt_req, "R2", "no fetch on hit", 32'(pt_req), 0);
    end else begin
      exp_misses++;
      chk(!rsp_valid && pt_req, tag, "miss fetch", {rsp_valid, pt_req}, 2'b01);
      chk(pt_vpn == v, "R3", "fetch vpn", pt_vpn, v);
      reply_and_check(v, tag);
    end
  endtask

  task automatic test_busy_ignore(input logic [19:0] v, input logic [19:0] other);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = v;
    @(negedge clk);
    exp_misses++;
    req_vpn = other;
    #1;
    chk(ready == 1'b0, "R9", "ready while busy", 32'(ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid && pt_vpn == v, "R9", "intruder ignored", pt_vpn, v);
    reply_and_check(v, "R9");
    chk(miss_cnt == 16'(exp_misses) && hit_cnt == 16'(exp_hits), "R9",
        "counters after intruder", miss_cnt, exp_misses);
  endtask

  task automatic test_flush(input logic [19:0] v);
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_vpn = v;
    #1;
    chk(ready == 1'b0, "R8", "ready during flush", 32'(ready), 0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    chk(!rsp_valid && !pt_req, "R8", "request blocked", {rsp_valid, pt_req}, 0);
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_val[i] = 1'b0; m_vpn[i] = '0; end
    repeat (3) @(negedge clk);
    chk(ready && !rsp_valid && !pt_req, "R1", "reset outputs",
        {ready, rsp_valid, pt_req}, 3'b100);
    chk(hit_cnt == 0 && miss_cnt == 0, "R1", "counters under reset", hit_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !rsp_valid && !pt_req, "R1", "after reset", {ready, rsp_valid, pt_req}, 3'b100);

    do_lookup(20'h00010, "R3");
    do_lookup(20'h00010, "R2");
    for (int i = 1; i < N; i++) do_lookup(20'h00010 + 20'(i), "R5");
    for (int i = 0; i < N; i++) do_lookup(20'h00010 + 20'(i), "R2");
    do_lookup(20'h00020, "R6");
    do_lookup(20'h00011, "R6");
    do_lookup(20'h00010, "R6");
    do_lookup(20'h00011, "R6");
    do_lookup(20'h00013, "R6");
    do_lookup(20'h80005, "R7");
    do_lookup(20'h80005, "R7");
    do_lookup(20'h00030, "R7");
    do_lookup(20'h00014, "R7");
    do_lookup(20'h00013, "R7");
    test_busy_ignore(20'h00040, 20'h00015);
    do_lookup(20'h00015, "R9");
    test_flush(20'h00017);
    do_lookup(20'h00020, "R8");
    for (int i = 1; i < N; i++) do_lookup(20'h00100 + 20'(i), "R5");
    do_lookup(20'h00200, "R6");
    do_lookup(20'h00020, "R5");
    do_lookup(20'h00107, "R5");

    @(negedge clk);
    chk(hit_cnt == 16'(exp_hits), "R10", "hit count", hit_cnt, exp_hits);
    chk(miss_cnt == 16'(exp_misses), "R10", "miss count", miss_cnt, exp_misses);
    chk(pt_req_edges == exp_misses, "R3", "one fetch per miss", pt_req_edges, exp_misses);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule